// File: doc/BRIEF.md
# Looping Step Sequencer Core

The block holds a small pattern of five rows by sixteen steps and plays it back one column at a time. When it is started, it walks through the steps on a single-cycle tempo enable. At every step it presents the five-bit column for that step, and another stage can use that column to sound notes or light a display. The loop can be four, eight or sixteen steps long. When the walk reaches the last step of the chosen length, it wraps to step 0.

The pattern is written in place. The user pauses on a step and drives the five write bits, and these bits become that step's column. A stop returns the block to idle and keeps the pattern. A start resumes from step 0. Only the asynchronous reset clears the pattern. All pins are plain control and status signals. No data stream passes the block edge, so there is no valid/ready handshake and no back-pressure. Inputs are sampled on the rising clock edge.

Top module: `step_seq_core`

## Requirements
- R1: While `rst_n` is low, and asynchronously on its fall, the block is idle (`idle`=1, `step_idx`=0, `col_bits`=0), and every stored pattern bit is cleared to 0.
- R2: While idle, `tick` has no effect and the block stays idle. A cycle with `start`=1 and `stop`=0 puts the block in play at step 0 after that edge, and no tick is needed.
- R3: In play, with `pause`=0 and `stop`=0, a cycle with `tick`=1 advances `step_idx` by one. A cycle with `tick`=0 holds it.
- R4: With `len_sel`=2'b00 the loop has 16 steps, and a tick at step 15 goes to step 0.
- R5: With `len_sel[1]`=1 the loop has 4 steps. With `len_sel`=2'b01 it has 8 steps. A tick at or beyond the last step of the selected length goes to step 0.
- R6: In play with `pause`=1, ticks do not move the step. Each such cycle writes `wr_bits` into the column of the current step, where bit r is row r. From the next cycle on, `col_bits` shows that value.
- R7: `stop`=1 in play returns the block to idle after that edge. Stop takes priority over `start` and over a write. The stored pattern is kept and is shown again after the next start.
- R8: In play with `pause`=0, `col_bits` equals the stored column of `step_idx`. While idle, `col_bits` and `step_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears the pattern |
| tick | input | 1 | Single-cycle tempo enable |
| start | input | 1 | Leave idle and begin at step 0 |
| stop | input | 1 | Return to idle, pattern kept |
| pause | input | 1 | Hold the current step and write its column |
| len_sel | input | 2 | Loop length: bit 1 set = 4, 2'b01 = 8, 2'b00 = 16 |
| wr_bits | input | 5 | Column value written while paused |
| step_idx | output | 4 | Current step, 0 while idle |
| col_bits | output | 5 | Column of the current step, 0 while idle |
| idle | output | 1 | High while in the idle state |

## Verification
A broken one-hot state shows at the ports within one tick. `step_idx` would then read an OR of two indices or freeze, and the bench compares it with an arithmetic step model after every tick.

A row written to the wrong step, or not written at all, shows when the loop is played back. That can be up to sixteen ticks after the write, so every column is read back over a full loop.

A wrong wrap point shows on the first tick at the end of the loop. Each length setting is swept for several loop periods, and the length is also changed while the step is past the new end.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int unsigned SEQ_STEPS = 16;
  localparam int unsigned SEQ_ROWS  = 5;
  localparam int unsigned SEQ_SW    = $clog2(SEQ_STEPS);
endpackage

// File: rtl/seq_fsm.sv
module seq_fsm #(
  parameter int unsigned NSTEPS = seq_pkg::SEQ_STEPS,
  localparam int unsigned SW = $clog2(NSTEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic          stop,
  input  logic          pause,
  input  logic [1:0]    len_sel,
  output logic          idle,
  output logic          playing,
  output logic [SW-1:0] step
);
  localparam logic [NSTEPS:0] IDLE_ST = (NSTEPS+1)'(1);
  localparam logic [NSTEPS:0] STEP0_ST = (NSTEPS+1)'(2);

  // bit 0 = idle, bit k+1 = step k
  logic [NSTEPS:0] st_q, st_d;
  logic [SW-1:0]   last;

  always_comb begin
    if (len_sel[1])      last = SW'(NSTEPS/4 - 1);
    else if (len_sel[0]) last = SW'(NSTEPS/2 - 1);
    else                 last = SW'(NSTEPS - 1);
  end

  always_comb begin
    step = '0;
    for (int k = 0; k < NSTEPS; k++)
      if (st_q[k+1]) step = step | SW'(k);
  end

  assign idle    = st_q[0];
  assign playing = ~st_q[0];

  always_comb begin
    st_d = st_q;
    if (st_q[0]) begin
      if (start && !stop) st_d = STEP0_ST;
    end else if (stop) begin
      st_d = IDLE_ST;
    end else if (tick && !pause) begin
      if (step >= last) st_d = STEP0_ST;
      else              st_d = st_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= IDLE_ST;
    else        st_q <= st_d;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start) |=> idle);
  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && !stop && !pause && tick && step < last) |=> (step == $past(step) + 1'b1));
  // R6
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && !stop && pause) |=> (playing && $stable(step)));
  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && stop) |=> (idle && step == '0));
endmodule

// File: rtl/seq_grid.sv
module seq_grid #(
  parameter int unsigned NROWS  = seq_pkg::SEQ_ROWS,
  parameter int unsigned NSTEPS = seq_pkg::SEQ_STEPS,
  localparam int unsigned SW = $clog2(NSTEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SW-1:0]    sel,
  input  logic [NROWS-1:0] wdata,
  output logic [NROWS-1:0] rdata
);
  for (genvar r = 0; r < NROWS; r++) begin : g_row
    logic [NSTEPS-1:0] row_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  row_q <= '0;
      else if (we) row_q[sel] <= wdata[r];
    assign rdata[r] = row_q[sel];
  end
endmodule

// File: rtl/step_seq_core.sv
module step_seq_core #(
  parameter int unsigned NROWS  = seq_pkg::SEQ_ROWS,
  parameter int unsigned NSTEPS = seq_pkg::SEQ_STEPS,
  localparam int unsigned SW = $clog2(NSTEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic             pause,
  input  logic [1:0]       len_sel,
  input  logic [NROWS-1:0] wr_bits,
  output logic [SW-1:0]    step_idx,
  output logic [NROWS-1:0] col_bits,
  output logic             idle
);
  logic          playing;
  logic [SW-1:0] step;
  logic [NROWS-1:0] rd;

  seq_fsm #(.NSTEPS(NSTEPS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
    .pause(pause), .len_sel(len_sel), .idle(idle), .playing(playing), .step(step)
  );

  seq_grid #(.NROWS(NROWS), .NSTEPS(NSTEPS)) u_grid (
    .clk(clk), .rst_n(rst_n), .we(playing & pause & ~stop), .sel(step),
    .wdata(wr_bits), .rdata(rd)
  );

  assign step_idx = step;
  assign col_bits = idle ? '0 : rd;

  // R6
  write_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && pause && !stop) |=> (col_bits == $past(wr_bits)));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && stop) |=> (col_bits == '0));
endmodule

// File: tb/tb_step_seq_core.sv
module tb_step_seq_core;
  logic clk = 0, rst_n = 0, tick = 0, start = 0, stop = 0, pause = 0;
  logic [1:0] len_sel = 2'b00;
  logic [4:0] wr_bits = '0;
  logic [3:0] step_idx;
  logic [4:0] col_bits;
  logic idle;
  int total = 0, bad = 0, m = 0;
  bit done = 0;

  always #2 clk = ~clk;

  step_seq_core dut (.clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
    .pause(pause), .len_sel(len_sel), .wr_bits(wr_bits), .step_idx(step_idx),
    .col_bits(col_bits), .idle(idle));

  function automatic logic [4:0] pat(int s);
    return 5'((s * 11 + 5) & 31);
  endfunction

  function automatic int len_of(logic [1:0] sel);
    return sel[1] ? 4 : (sel[0] ? 8 : 16);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1; cyc(); tick = 0;
    m = (m >= len_of(len_sel) - 1) ? 0 : m + 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #9;
    chk("R1 idle", idle, 1); chk("R1 step", step_idx, 0); chk("R1 col", col_bits, 0);
    @(negedge clk); rst_n = 1; cyc();
    // R2: ticks ignored in idle
    for (int i = 0; i < 3; i++) begin tick = 1; cyc(); tick = 0; chk("R2 idle tick", idle, 1); end
    start = 1; cyc(); start = 0; m = 0;
    chk("R2 start idle", idle, 0); chk("R2 start step", step_idx, 0);
    // R3/R4/R5: sweep every length setting
    for (int l = 0; l < 4; l++) begin
      len_sel = 2'(l);
      for (int i = 0; i < 40; i++) begin
        do_tick();
        chk(l == 0 ? "R4 step" : "R5 step", step_idx, m);
        if (i % 7 == 3) begin cyc(); chk("R3 hold", step_idx, m); end
      end
    end
    // R5: length cut while past new end
    len_sel = 2'b00;
    while (m != 10) do_tick();
    chk("R3 at 10", step_idx, 10);
    len_sel = 2'b10; do_tick(); chk("R5 beyond", step_idx, 0);
    len_sel = 2'b00;
    // R6: program every step
    for (int s = 0; s < 16; s++) begin
      pause = 1; wr_bits = pat(s); cyc();
      chk("R6 col", col_bits, pat(s)); chk("R6 step", step_idx, s);
      tick = 1; cyc(); tick = 0;
      chk("R6 pause hold", step_idx, s);
      pause = 0; do_tick();
    end
    chk("R4 wrap", step_idx, 0);
    // R8: read back full loop
    for (int s = 0; s < 16; s++) begin
      chk("R8 col", col_bits, pat(m)); do_tick();
    end
    // R7: stop beats start, pattern kept
    while (m != 5) do_tick();
    stop = 1; start = 1; pause = 1; wr_bits = 5'd0; cyc(); stop = 0; start = 0; pause = 0;
    chk("R7 idle", idle, 1); chk("R8 idle step", step_idx, 0); chk("R8 idle col", col_bits, 0);
    start = 1; cyc(); start = 0; m = 0;
    chk("R7 kept 0", col_bits, pat(0));
    for (int s = 1; s < 16; s++) begin do_tick(); chk("R7 kept", col_bits, pat(s)); end
    // R1: async reset mid-run clears pattern
    do_tick(); do_tick();
    #1 rst_n = 0; #0.5;
    chk("R1 async idle", idle, 1); chk("R1 async step", step_idx, 0);
    @(negedge clk); rst_n = 1; cyc();
    start = 1; cyc(); start = 0; m = 0;
    for (int s = 0; s < 16; s++) begin chk("R1 cleared", col_bits, 0); do_tick(); end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule